// File: doc/BRIEF.md
# Button-Driven Hexadecimal Step Counter with Seven-Segment Output

This block turns operator presses into counting steps and shows the running count as a single hexadecimal digit. It has two press sources, and both are active low. The first is a push button that already has hardware filtering on the board, so its level is used as it arrives. The second is a bare manual contact that can chatter, so it goes through an on-chip synchroniser and a stability filter first. After inversion, the two sources are ORed into one press level. A rising-edge detector then turns each new press into a single-cycle step.

The step drives a 4-bit wrapping counter. The count goes through a hexadecimal font lookup to an 8-bit active-low segment bus. That bus has seven digit segments and a decimal point that is always dark. The filter length is a parameter counted in clock cycles, so it is set from the clock frequency and the longest bounce to reject. The default suits a 50 MHz clock with a 40 ms bounce.

Top module: `hex_step_display`

## Requirements
- R1: A clock edge with `rst_n` low clears the count to 0. After that edge, `seg_n` reads 8'hC0, the digit 0 with the decimal point dark.
- R2: The push-button input is not filtered. When `btn_n` is first sampled low on an edge, the count rises by one on the second following edge. A low level lasting a single cycle is enough.
- R3: A press held for any number of cycles advances the count exactly once. Releasing the press does not step the count.
- R4: The switch input passes through two synchronising flops and then a run counter. The switch must be sampled low on DEBOUNCE_CYCLES consecutive edges before a step happens. When it is, the displayed value changes on edge DEBOUNCE_CYCLES+4, counted from the first low sample. Shorter low bursts, including repeated chatter, never step.
- R5: The two inverted sources are ORed. While either one keeps the merged level high, overlapping activity on the other causes no extra step.
- R6: The count wraps from 15 to 0 on the next step.
- R7: Bit 7 of `seg_n` is the decimal point, and it is driven high (unlit) at all times.
- R8: Bits 0..6 of `seg_n` are segments a..g, and a segment lights when its bit is 0. The lit-segment patterns, as hex values of bits 6..0 for digits 0..F, are: 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71. This gives a lowercase b and d. `seg_n` is {1'b1, ~pattern}.
- R9: The count changes by exactly one on a step and holds on every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| btn_n | input | 1 | Board-filtered push button, low when pressed |
| sw_n | input | 1 | Unfiltered manual switch, low when closed |
| seg_n | output | 8 | Segment drive, active low; bit 7 is the decimal point, bits 0..6 are segments a..g |

## Verification
The bench targets the edges of the switch filter:
- A burst one cycle shorter than the filter length must not step; a burst of exactly the filter length must step. A filter that is off by one in either direction changes the count when it should not, or misses the step.
- Chattering bursts check that the run counter restarts on every high sample. A counter that only paused instead of restarting would eventually step on the accumulated count.

Presses that are held for long periods, and presses on both sources that overlap, would show up as double counts in a detector that is level-sensitive, or in a merge that stepped once per source.

The bench also exercises:
- the wrap from F back to 0, which a saturating counter would miss;
- the exact step latency on both paths, which an added or missing pipeline stage would shift;
- every one of the sixteen glyphs, which would expose a mistaken entry or reversed segment order.

// File: rtl/hsd_pkg.sv
// Package: shared widths and the hexadecimal glyph table for the step display.
// Assumes segment order a..g on bits 0..6, with the decimal point above them.
package hsd_pkg;

    localparam int unsigned DIGIT_W = 4;
    localparam int unsigned GLYPH_W = 7;
    localparam int unsigned SEG_W   = GLYPH_W + 1;

    // Lit-segment pattern (1 = segment on) for one hexadecimal digit.
    function automatic logic [GLYPH_W-1:0] glyph_of(input logic [DIGIT_W-1:0] digit);
        logic [GLYPH_W-1:0] pat;
        case (digit)
            4'h0:    pat = 7'h3F;
            4'h1:    pat = 7'h06;
            4'h2:    pat = 7'h5B;
            4'h3:    pat = 7'h4F;
            4'h4:    pat = 7'h66;
            4'h5:    pat = 7'h6D;
            4'h6:    pat = 7'h7D;
            4'h7:    pat = 7'h07;
            4'h8:    pat = 7'h7F;
            4'h9:    pat = 7'h6F;
            4'hA:    pat = 7'h77;
            4'hB:    pat = 7'h7C;
            4'hC:    pat = 7'h39;
            4'hD:    pat = 7'h5E;
            4'hE:    pat = 7'h79;
            default: pat = 7'h71;
        endcase
        return pat;
    endfunction

endpackage

// File: rtl/hsd_switch_filter.sv
// Module: stability filter for a chattering active-low contact.
// The contact is inverted and passed through two flops to resynchronise it.
// A run counter then counts edges on which the contact was closed and
// restarts on any open sample. The output is high while the run has reached
// HOLD_CYCLES. Assumes HOLD_CYCLES >= 1.
module hsd_switch_filter #(
    parameter int unsigned HOLD_CYCLES = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_n,
    output logic steady
);

    localparam int unsigned RUN_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(HOLD_CYCLES);
    localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

    logic             meta_q;
    logic             sync_q;
    logic [RUN_W-1:0] run_q;

    // Bring the inverted contact into the clock domain through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= ~raw_n;
            sync_q <= meta_q;
        end
    end

    // Count consecutive closed samples, saturate at the limit, restart when open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!sync_q) begin
            run_q <= '0;
        end else if (run_q != RUN_MAX) begin
            run_q <= run_q + RUN_ONE;
        end
    end

    // Declare the contact settled once the run has reached the limit.
    always_comb begin
        steady = (run_q == RUN_MAX);
    end

    // R4: a settled output needs the synchronised contact closed on the edge before.
    p_steady_needs_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        steady |-> $past(sync_q))
        else $error("steady output without a closed synchronised sample");

    // R4: an open synchronised sample clears the settled state on the next edge.
    p_open_drops_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_q |=> !steady)
        else $error("steady output survived an open sample");

endmodule

// File: rtl/hsd_rise_pulse.sv
// Module: rising-edge detector for the merged press level.
// The level is registered once, then delayed again. The step is the first
// copy ANDed with the inverse of the second, so it lasts one clock however
// long the level stays high. Assumes the level is stable around clock edges.
module hsd_rise_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic pulse
);

    logic now_q;
    logic old_q;

    // Keep the current and the previous sample of the level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now_q <= 1'b0;
            old_q <= 1'b0;
        end else begin
            now_q <= level;
            old_q <= now_q;
        end
    end

    // Fire only on the cycle where the level is newly high.
    always_comb begin
        pulse = now_q & ~old_q;
    end

    // R3: a step never lasts longer than one cycle.
    p_single_cycle_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse)
        else $error("step pulse lasted more than one cycle");

    // R2: a step follows a high level sampled on the previous edge.
    p_step_follows_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(level))
        else $error("step without a preceding high level");

endmodule

// File: rtl/hsd_step_counter.sv
// Module: wrapping up-counter that advances by one on each step pulse.
// Assumes step is a single-cycle strobe; it wraps naturally at 2**CNT_W.
module hsd_step_counter #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;

    // Clear on reset, otherwise add one whenever a step arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (step) begin
            count_q <= count_q + CNT_ONE;
        end
    end

    assign count = count_q;

    // R1: a reset edge leaves the count at zero.
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (count == '0))
        else $error("count not cleared by reset");

    // R9: a step advances the count by exactly one.
    p_step_adds_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (count == $past(count) + CNT_ONE))
        else $error("step did not add exactly one");

    // R9: with no step the count holds.
    p_hold_without_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(count))
        else $error("count moved without a step");

    // R6: the top value rolls over to zero.
    p_wrap_to_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && count == CNT_LAST) |=> (count == '0))
        else $error("count did not wrap to zero");

endmodule

// File: rtl/hsd_hex_drive.sv
// Module: converts a 4-bit value into active-low seven-segment drive with a
// dark decimal point. Purely combinational; the value comes from a register.
module hsd_hex_drive
    import hsd_pkg::*;
(
    input  logic [DIGIT_W-1:0] digit,
    output logic [SEG_W-1:0]   seg_n
);

    logic [GLYPH_W-1:0] lit;

    // Look up the glyph and invert it for the sinking outputs.
    always_comb begin
        lit   = glyph_of(digit);
        seg_n = {1'b1, ~lit};
    end

    // R8: every digit lights at least two segments, so no code blanks the display.
    always_comb begin
        p_glyph_not_blank_r8: assert ($countones(~seg_n[GLYPH_W-1:0]) >= 2)
            else $error("glyph lights fewer than two segments");
    end

endmodule

// File: rtl/hex_step_display.sv
// Module: top of the press-to-display chain.
// The filtered button is inverted and ORed with the filtered switch. The
// merged level is edge-detected into steps, the steps drive a 4-bit counter,
// and the count is shown as one hex digit. Assumes btn_n is already clean
// enough to use directly.
module hex_step_display #(
    parameter int unsigned DEBOUNCE_CYCLES = 2_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       btn_n,
    input  logic       sw_n,
    output logic [7:0] seg_n
);

    import hsd_pkg::*;

    logic               sw_steady;
    logic               press_level;
    logic               step;
    logic [DIGIT_W-1:0] count;

    hsd_switch_filter #(
        .HOLD_CYCLES (DEBOUNCE_CYCLES)
    ) u_switch_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_n  (sw_n),
        .steady (sw_steady)
    );

    // Merge the inverted button with the settled switch into one press level.
    always_comb begin
        press_level = ~btn_n | sw_steady;
    end

    hsd_rise_pulse u_rise_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .level (press_level),
        .pulse (step)
    );

    hsd_step_counter #(
        .CNT_W (DIGIT_W)
    ) u_step_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .count (count)
    );

    hsd_hex_drive u_hex_drive (
        .digit (count),
        .seg_n (seg_n)
    );

    // R5: a step cannot occur while the merged level was already high on the previous edge.
    p_merge_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(press_level) && press_level) |=> !step)
        else $error("extra step while the merged level stayed high");

endmodule

// File: tb/test_hex_step_display.sv
// Bench: a behavioural cycle model is compared on every falling edge, and
// directed checks with hand-computed expected counts are added on top.
module test_hex_step_display;

    localparam int CLK_PERIOD = 10;
    localparam int LEN        = 6;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       btn_n = 1'b1;
    logic       sw_n  = 1'b1;
    logic [7:0] seg_n;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    bit    model_on = 1'b0;
    string phase    = "R1";

    hex_step_display #(.DEBOUNCE_CYCLES(LEN)) i_hex_step_display (
        .clk   (clk),
        .rst_n (rst_n),
        .btn_n (btn_n),
        .sw_n  (sw_n),
        .seg_n (seg_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Expected drive for a count, per R7 and R8.
    function automatic logic [7:0] want(input int value);
        logic [6:0] lit;
        case (value % 16)
            0: lit = 7'h3F;  1: lit = 7'h06;  2: lit = 7'h5B;  3: lit = 7'h4F;
            4: lit = 7'h66;  5: lit = 7'h6D;  6: lit = 7'h7D;  7: lit = 7'h07;
            8: lit = 7'h7F;  9: lit = 7'h6F; 10: lit = 7'h77; 11: lit = 7'h7C;
           12: lit = 7'h39; 13: lit = 7'h5E; 14: lit = 7'h79; default: lit = 7'h71;
        endcase
        return {1'b1, ~lit};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: seg_n actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Behavioural model: history of switch samples, the run length, and merged-level history.
    int m_sw_hist[$];
    int m_run   = 0;
    int m_lev1  = 0;
    int m_lev2  = 0;
    int m_count = 0;

    always @(posedge clk) begin
        int settled;
        int merged;
        if (!rst_n) begin
            m_sw_hist = {};
            m_run = 0; m_lev1 = 0; m_lev2 = 0; m_count = 0;
        end else begin
            settled = (m_run >= LEN) ? 1 : 0;
            merged  = ((btn_n == 1'b0) || settled != 0) ? 1 : 0;
            if (m_lev1 == 1 && m_lev2 == 0) m_count = (m_count + 1) % 16;
            m_lev2 = m_lev1;
            m_lev1 = merged;
            // switch seen after two synchronising stages
            if (m_sw_hist.size() >= 2 && m_sw_hist[m_sw_hist.size()-2] == 1)
                m_run = (m_run < LEN) ? m_run + 1 : LEN;
            else
                m_run = 0;
            m_sw_hist.push_back(sw_n ? 0 : 1);
            if (m_sw_hist.size() > 2) void'(m_sw_hist.pop_front());
        end
    end

    // Compare the model against the port on every falling edge (R7 included).
    always @(negedge clk) begin
        if (model_on) begin
            check(phase, seg_n, want(m_count));
            check("R7", {7'h00, seg_n[7]}, 8'h01);
        end
    end

    // Watchdog: an overrun counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_fail++;
            $display("FAIL watchdog: cycles actual %0d expected below %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tap();
        btn_n = 1'b0;
        @(negedge clk);
        btn_n = 1'b1;
        idle(3);
    endtask

    int exp_count = 0;

    initial begin
        idle(3);
        rst_n = 1'b1;
        model_on = 1'b1;
        check("R1", seg_n, 8'hC0);

        // R2: one-cycle tap, exact latency
        phase = "R2";
        btn_n = 1'b0;
        @(negedge clk);
        check("R2", seg_n, want(0));
        btn_n = 1'b1;
        @(negedge clk);
        exp_count = 1;
        check("R2", seg_n, want(exp_count));
        idle(3);

        // R3: long hold steps once, release does not step
        phase = "R3";
        btn_n = 1'b0;
        idle(25);
        exp_count = 2;
        check("R3", seg_n, want(exp_count));
        btn_n = 1'b1;
        idle(5);
        check("R3", seg_n, want(exp_count));

        // R4: burst one short of the filter length is ignored
        phase = "R4";
        sw_n = 1'b0;
        idle(LEN - 1);
        sw_n = 1'b1;
        idle(LEN + 6);
        check("R4", seg_n, want(exp_count));

        // R4: chatter that never settles is ignored
        for (int k = 0; k < 5; k++) begin
            sw_n = 1'b0;
            idle(LEN - 2);
            sw_n = 1'b1;
            idle(1);
        end
        idle(LEN + 6);
        check("R4", seg_n, want(exp_count));

        // R4: a full-length closure steps on edge LEN+4
        sw_n = 1'b0;
        idle(LEN + 3);
        check("R4", seg_n, want(exp_count));
        idle(1);
        exp_count = 3;
        check("R4", seg_n, want(exp_count));
        idle(10);
        sw_n = 1'b1;
        idle(LEN + 6);
        check("R4", seg_n, want(exp_count));

        // R5: both sources overlapping give one step
        phase = "R5";
        btn_n = 1'b0;
        sw_n  = 1'b0;
        idle(LEN + 12);
        btn_n = 1'b1;
        idle(8);
        sw_n = 1'b1;
        idle(LEN + 6);
        exp_count = 4;
        check("R5", seg_n, want(exp_count));

        // R8: walk every glyph up to F
        phase = "R8";
        while (exp_count < 15) begin
            tap();
            exp_count++;
            check("R8", seg_n, want(exp_count));
        end

        // R6: wrap from F to 0
        phase = "R6";
        tap();
        exp_count = 0;
        check("R6", seg_n, 8'hC0);
        tap();
        tap();
        exp_count = 2;
        check("R9", seg_n, want(exp_count));

        // R1: reset in mid-count clears the display
        phase = "R1";
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", seg_n, 8'hC0);
        rst_n = 1'b1;
        idle(3);
        check("R1", seg_n, 8'hC0);

        finish_run();
    end

endmodule